// File: doc/BRIEF.md
# Error Event Capture and Interrupt Unit

This unit gathers single-cycle error pulses from a queue-management engine and records each one in a sticky status register. Software clears that register by writing ones. A single interrupt line goes high whenever a recorded error is also enabled in a separate enable register.

Next to the sticky status, a capture-status register marks which error kinds have been recorded. Three context fields hold the details of the first error in their group: the portal type and number, the queue identifier, and the failing memory ID and entry address. A field stays frozen while any error of its group is marked in capture-status. Software re-arms a group by writing the marked bits back to capture-status. This write is separate from clearing the interrupt status.

All registers are reached through a plain 32-bit word port. Word index 0 is the interrupt status (write ones to clear). Index 1 is the enable register (read/write). Index 2 is the capture-status register (write ones to re-arm). Index 3 is the capture-information word (read only). Index 4 is the capture-address word (read only). Indices 5 to 7 read as zero. Writes take effect on the clock edge where `req_i` and `we_i` are both high. Reads are combinational from `addr_i`.

Top module: `err_capture_unit`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: An event pulse on `evt_i` sets the same bit of the interrupt status on the next clock edge, but only for the defined positions 29..23, 17, 16, 11..8 and 4..0 (mask 0x3F830F1F). Pulses on any other position leave every register unchanged.
- R3: Writing to index 0 clears each status bit written as one and leaves the bits written as zero unchanged.
- R4: `irq_o` is high exactly when the status AND the enable register is nonzero.
- R5: The enable register stores writes at the defined positions. Undefined positions read as zero in the status, enable and capture-status registers.
- R6: Each event also sets its bit in capture-status. Writing ones to index 2 clears those bits. Clearing the interrupt status does not clear capture-status, and clearing capture-status does not clear the interrupt status.
- R7: The capture-information word has the queue ID in bits 23..0, the portal number in bits 28..24 and the portal type in bit 29 (1 means a direct-connect portal). Bits 31..30 read zero. The portal fields load only for the portal group: bits 0, 2, 3, 8, 9, 10, 11, 16 and 17.
- R8: The queue-ID field loads only for the queue group: bits 0, 1, 2, 3, 8, 10 and 17.
- R9: The capture-address word has the memory ID in bits 27..24 and the entry address in bits 11..0. All other bits read zero. It loads only for the ECC errors at bits 24 and 25.
- R10: While any bit of a group is set in capture-status, new events of that group do not change that group's context field.
- R11: When an event and a clearing write reach the same status or capture-status bit in one cycle, the bit ends up set.
- R12: Writes to indices 3 and 4 have no effect on the values read there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | Error event pulses, one bit per error kind |
| evt_qid_i | input | 24 | Queue ID belonging to the current event |
| evt_pnum_i | input | 5 | Portal number belonging to the current event |
| evt_dcp_i | input | 1 | Portal type of the current event, 1 = direct-connect |
| evt_memid_i | input | 4 | Memory ID belonging to an ECC event |
| evt_maddr_i | input | 12 | Failing entry address belonging to an ECC event |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high together with req_i |
| addr_i | input | 3 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Error interrupt |

## Verification
The two functions that can land on the same cycle are event recording and the software clear. This applies both to the interrupt status and to the capture-status re-arm, and a re-arm can also coincide with a new event of the same group. The bench drives an event pulse and a clearing write in the same clock cycle. It uses bit sets that overlap and that do not, then reads back both registers and the context words. A bit that was both hit and cleared must read as set. A bit that was only cleared must read as clear. A group re-armed on the same cycle as one of its events must take that event's context.

// File: rtl/err_capture_unit.sv
module err_capture_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] evt_i,
  input  logic [23:0] evt_qid_i,
  input  logic [4:0]  evt_pnum_i,
  input  logic        evt_dcp_i,
  input  logic [3:0]  evt_memid_i,
  input  logic [11:0] evt_maddr_i,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  localparam logic [31:0] VALID_M  = 32'h3F83_0F1F;
  localparam logic [31:0] PORTAL_M = 32'h0003_0F0D;
  localparam logic [31:0] QUEUE_M  = 32'h0002_050F;
  localparam logic [31:0] MEM_M    = 32'h0300_0000;
  localparam logic [2:0]  A_STAT = 3'd0, A_EN = 3'd1, A_CAP = 3'd2,
                          A_INFO = 3'd3, A_ADDR = 3'd4;

  logic [31:0] st_q, en_q, cap_q;
  logic [23:0] qid_q;
  logic [4:0]  pnum_q;
  logic        ptype_q;
  logic [3:0]  memid_q;
  logic [11:0] maddr_q;

  wire        wr       = req_i & we_i;
  wire [31:0] evt      = evt_i & VALID_M;
  wire [31:0] st_clr   = (wr && addr_i == A_STAT) ? wdata_i : 32'h0;
  wire [31:0] cap_clr  = (wr && addr_i == A_CAP)  ? wdata_i : 32'h0;
  wire [31:0] cap_keep = cap_q & ~cap_clr;

  wire ld_portal = (|(evt & PORTAL_M)) && !(|(cap_keep & PORTAL_M));
  wire ld_queue  = (|(evt & QUEUE_M))  && !(|(cap_keep & QUEUE_M));
  wire ld_mem    = (|(evt & MEM_M))    && !(|(cap_keep & MEM_M));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= '0;
      en_q    <= '0;
      cap_q   <= '0;
      qid_q   <= '0;
      pnum_q  <= '0;
      ptype_q <= 1'b0;
      memid_q <= '0;
      maddr_q <= '0;
    end else begin
      st_q  <= (st_q & ~st_clr) | evt;
      cap_q <= cap_keep | evt;
      if (wr && addr_i == A_EN) en_q <= wdata_i & VALID_M;
      if (ld_portal) begin
        pnum_q  <= evt_pnum_i;
        ptype_q <= evt_dcp_i;
      end
      if (ld_queue) qid_q <= evt_qid_i;
      if (ld_mem) begin
        memid_q <= evt_memid_i;
        maddr_q <= evt_maddr_i;
      end
    end
  end

  always_comb begin
    case (addr_i)
      A_STAT:  rdata_o = st_q;
      A_EN:    rdata_o = en_q;
      A_CAP:   rdata_o = cap_q;
      A_INFO:  rdata_o = {2'b00, ptype_q, pnum_q, qid_q};
      A_ADDR:  rdata_o = {4'h0, memid_q, 12'h000, maddr_q};
      default: rdata_o = 32'h0;
    endcase
  end

  assign irq_o = |(st_q & en_q);
endmodule

// File: rtl/err_capture_unit_chk.sv
module err_capture_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] evt_i,
  input logic        req_i,
  input logic        we_i,
  input logic [2:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic        irq_o,
  input logic [31:0] st_q,
  input logic [31:0] en_q,
  input logic [31:0] cap_q,
  input logic [4:0]  pnum_q,
  input logic        ptype_q,
  input logic [3:0]  memid_q,
  input logic [11:0] maddr_q
);
  localparam logic [31:0] VM = 32'h3F83_0F1F;
  localparam logic [31:0] PM = 32'h0003_0F0D;
  localparam logic [31:0] MM = 32'h0300_0000;

  // R2
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & VM)) |=> ((st_q & $past(evt_i & VM)) == $past(evt_i & VM)));

  // R5
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((st_q | en_q | cap_q) & ~VM) == 32'h0));

  // R4
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 32'h0) |-> !irq_o);

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && we_i && addr_i == 3'd0) |=> ((st_q & $past(wdata_i & ~evt_i)) == 32'h0));

  // R10
  portal_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((cap_q & PM) != 32'h0) && !(req_i && we_i && addr_i == 3'd2))
      |=> ($stable(pnum_q) && $stable(ptype_q)));

  // R10
  mem_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((cap_q & MM) != 32'h0) && !(req_i && we_i && addr_i == 3'd2))
      |=> ($stable(memid_q) && $stable(maddr_q)));
endmodule

bind err_capture_unit err_capture_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .irq_o(irq_o), .st_q(st_q),
  .en_q(en_q), .cap_q(cap_q), .pnum_q(pnum_q), .ptype_q(ptype_q),
  .memid_q(memid_q), .maddr_q(maddr_q)
);

// File: tb/tb_err_capture_unit.sv
module tb_err_capture_unit;
  localparam logic [31:0] VM = 32'h3F83_0F1F;
  localparam logic [31:0] PM = 32'h0003_0F0D;
  localparam logic [31:0] QM = 32'h0002_050F;
  localparam logic [31:0] MM = 32'h0300_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_i = '0;
  logic [23:0] evt_qid_i = '0;
  logic [4:0]  evt_pnum_i = '0;
  logic        evt_dcp_i = 1'b0;
  logic [3:0]  evt_memid_i = '0;
  logic [11:0] evt_maddr_i = '0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  logic [31:0] m_cap;
  logic [23:0] m_qid;
  logic [4:0]  m_pnum;
  logic        m_ptype;
  logic [3:0]  m_memid;
  logic [11:0] m_maddr;

  always #10 clk = ~clk;

  err_capture_unit dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .evt_qid_i(evt_qid_i),
    .evt_pnum_i(evt_pnum_i), .evt_dcp_i(evt_dcp_i), .evt_memid_i(evt_memid_i),
    .evt_maddr_i(evt_maddr_i), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic rchk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic drive(input logic [31:0] ev, input logic w, input logic [2:0] a,
                       input logic [31:0] d, input logic [23:0] q, input logic [4:0] pn,
                       input logic dc, input logic [3:0] mid, input logic [11:0] ma);
    @(negedge clk);
    evt_i = ev; evt_qid_i = q; evt_pnum_i = pn; evt_dcp_i = dc;
    evt_memid_i = mid; evt_maddr_i = ma;
    req_i = w; we_i = w; addr_i = a; wdata_i = d;
    @(negedge clk);
    evt_i = '0; req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    drive(32'h0, 1'b1, a, d, '0, '0, 1'b0, '0, '0);
  endtask

  // Bench model of context loading per R7..R10, applied after any same-cycle re-arm
  task automatic model_evt(input logic [31:0] ev, input logic [31:0] rearm,
                           input logic [23:0] q, input logic [4:0] pn, input logic dc,
                           input logic [3:0] mid, input logic [11:0] ma);
    logic [31:0] e, keep;
    e = ev & VM;
    keep = m_cap & ~rearm;
    if ((e & PM) != 0 && (keep & PM) == 0) begin m_pnum = pn; m_ptype = dc; end
    if ((e & QM) != 0 && (keep & QM) == 0) m_qid = q;
    if ((e & MM) != 0 && (keep & MM) == 0) begin m_memid = mid; m_maddr = ma; end
    m_cap = keep | e;
  endtask

  task automatic pulse(input logic [31:0] ev, input logic [23:0] q, input logic [4:0] pn,
                       input logic dc, input logic [3:0] mid, input logic [11:0] ma);
    model_evt(ev, 32'h0, q, pn, dc, mid, ma);
    drive(ev, 1'b0, 3'd0, 32'h0, q, pn, dc, mid, ma);
  endtask

  function automatic logic [31:0] m_info();
    return {2'b00, m_ptype, m_pnum, m_qid};
  endfunction

  function automatic logic [31:0] m_addr();
    return {4'h0, m_memid, 12'h000, m_maddr};
  endfunction

  initial begin
    #4ms;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    m_cap = '0; m_qid = '0; m_pnum = '0; m_ptype = 1'b0; m_memid = '0; m_maddr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int a = 0; a < 8; a++) rchk("R1 reset value", 3'(a), 32'h0);
    chk("R1 irq after reset", {31'h0, irq_o}, 32'h0);

    wr(3'd1, 32'hFFFF_FFFF);
    rchk("R5 enable defined bits", 3'd1, VM);
    wr(3'd1, 32'h0);
    rchk("R5 enable cleared", 3'd1, 32'h0);

    // Sweep every bit position
    for (int b = 0; b < 32; b++) begin
      logic [31:0] bit_m;
      logic [23:0] q;
      logic [4:0]  pn;
      logic [3:0]  mid;
      logic [11:0] ma;
      bit_m = 32'h1 << b;
      q  = 24'(b * 24'h01_0203 + 7);
      pn = 5'(b + 3);
      mid = 4'(b);
      ma = 12'(b * 131 + 5);
      pulse(bit_m, q, pn, b[0], mid, ma);
      rchk($sformatf("R2 status bit %0d", b), 3'd0, bit_m & VM);
      chk($sformatf("R4 irq masked bit %0d", b), {31'h0, irq_o}, 32'h0);
      wr(3'd1, bit_m);
      chk($sformatf("R4 irq enabled bit %0d", b), {31'h0, irq_o}, ((bit_m & VM) != 0) ? 32'h1 : 32'h0);
      rchk($sformatf("R6 capture status bit %0d", b), 3'd2, bit_m & VM);
      rchk($sformatf("R7 R8 capture info bit %0d", b), 3'd3, m_info());
      rchk($sformatf("R9 capture address bit %0d", b), 3'd4, m_addr());
      wr(3'd0, bit_m);
      rchk($sformatf("R3 status cleared bit %0d", b), 3'd0, 32'h0);
      rchk($sformatf("R6 capture kept after clear bit %0d", b), 3'd2, bit_m & VM);
      wr(3'd2, bit_m);
      m_cap = m_cap & ~bit_m;
      rchk($sformatf("R6 capture re-armed bit %0d", b), 3'd2, 32'h0);
      wr(3'd1, 32'h0);
    end

    // R12 read-only words
    wr(3'd3, 32'hFFFF_FFFF);
    rchk("R12 info ignores writes", 3'd3, m_info());
    wr(3'd4, 32'hFFFF_FFFF);
    rchk("R12 address ignores writes", 3'd4, m_addr());

    // R10 freeze of each group
    pulse(32'h1, 24'hAAAA01, 5'd9, 1'b1, 4'h3, 12'h111);
    pulse(32'h4, 24'hBBBB02, 5'd17, 1'b0, 4'h4, 12'h222);
    rchk("R10 portal and queue frozen", 3'd3, {2'b00, 1'b1, 5'd9, 24'hAAAA01});
    pulse(32'h0100_0000, 24'h0, 5'd0, 1'b0, 4'hC, 12'hABC);
    pulse(32'h0200_0000, 24'h0, 5'd0, 1'b0, 4'h5, 12'h456);
    rchk("R10 address frozen", 3'd4, {4'h0, 4'hC, 12'h000, 12'hABC});
    wr(3'd2, 32'h1); m_cap = m_cap & ~32'h1;
    pulse(32'h8, 24'hCCCC03, 5'd21, 1'b0, 4'h0, 12'h0);
    rchk("R10 group still held by other bit", 3'd3, {2'b00, 1'b1, 5'd9, 24'hAAAA01});
    wr(3'd2, 32'hFFFF_FFFF); m_cap = '0;
    pulse(32'h8, 24'hCCCC03, 5'd21, 1'b0, 4'h0, 12'h0);
    rchk("R10 reload after full re-arm", 3'd3, {2'b00, 1'b0, 5'd21, 24'hCCCC03});
    pulse(32'h0001_0000, 24'hDDDD04, 5'd2, 1'b1, 4'h0, 12'h0);
    rchk("R8 verb error keeps queue id", 3'd3, {2'b00, 1'b0, 5'd21, 24'hCCCC03});
    wr(3'd2, 32'hFFFF_FFFF); m_cap = '0;
    pulse(32'h2, 24'hEEEE05, 5'd30, 1'b1, 4'h0, 12'h0);
    rchk("R7 channel error loads no portal", 3'd3, {2'b00, 1'b0, 5'd21, 24'hEEEE05});
    wr(3'd2, 32'hFFFF_FFFF); m_cap = '0;
    wr(3'd0, 32'hFFFF_FFFF);
    rchk("R3 all-ones clear", 3'd0, 32'h0);

    // R11 event against clear in the same cycle
    pulse(32'h1, 24'h1, 5'd1, 1'b0, 4'h0, 12'h0);
    drive(32'h10, 1'b1, 3'd0, 32'h11, '0, '0, 1'b0, '0, '0);
    model_evt(32'h10, 32'h0, '0, '0, 1'b0, '0, '0);
    rchk("R11 status event wins over clear", 3'd0, 32'h10);
    drive(32'h4, 1'b1, 3'd2, 32'h15, 24'h777777, 5'd7, 1'b1, '0, '0);
    model_evt(32'h4, 32'h15, 24'h777777, 5'd7, 1'b1, '0, '0);
    rchk("R11 capture event wins over re-arm", 3'd2, 32'h4);
    rchk("R11 re-armed group takes new context", 3'd3, m_info());
    rchk("R6 status untouched by re-arm", 3'd0, 32'h14);

    // R4 multi-bit irq
    wr(3'd1, 32'h10);
    chk("R4 irq with overlap", {31'h0, irq_o}, 32'h1);
    wr(3'd1, 32'h2000_0000);
    chk("R4 irq without overlap", {31'h0, irq_o}, 32'h0);
    pulse(32'hFFFF_FFFF, 24'h0, 5'd0, 1'b0, 4'h0, 12'h0);
    rchk("R2 all events at once", 3'd0, VM);
    chk("R4 irq after all events", {31'h0, irq_o}, 32'h1);
    wr(3'd0, 32'h2000_0000);
    chk("R4 irq drops on clear", {31'h0, irq_o}, 32'h0);
    rchk("R3 other bits kept", 3'd0, VM & ~32'h2000_0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule